// File: doc/BRIEF.md
# Three-Phase Bridge Gate Control Logic

This block turns per-leg switching commands into the six gate-drive signals of a three-leg power bridge. Every leg has a phase input, which picks whether its upper or its lower switch conducts, and a leg enable. When a leg enable is low, both switches of that leg are off and the leg output floats. Whenever a leg moves from one switch to the other, the block holds both switches off for a programmable number of clock cycles. This dead time stops shoot-through.

A single active-low enable line is shared by the whole bridge and is open-drain in nature. An external driver can pull the line low to switch off all six gates. The block pulls the same line low through its own pull-down request whenever an overcurrent flag for any upper switch, or the over-temperature flag, is raised. Every input reaches the logic through a two-flop synchronizer. After any disable is released, a leg starts again from both-off and waits out the whole dead time before it turns a switch on.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: With the leg enabled and the shared line high, phase_i bit = 1 selects the upper gate (gate_hi_o) and phase_i bit = 0 selects the lower gate (gate_lo_o) of that leg.
- R2: A low leg_en_i bit turns both gates of that leg off 3 clock edges after the input changes. While the leg is disabled, phase changes on it produce no gate activity.
- R3: A low level on en_line_i (the shared line) turns all six gates off 3 clock edges after the line falls, whatever the per-leg inputs are.
- R4: On a phase change, the conducting gate turns off 3 edges after the input change. The opposite gate turns on exactly DEAD_CYC edges after that, with both gates off in between.
- R5: When a leg enable or the shared line returns high, the leg goes from both-off through a full DEAD_CYC wait. Its selected gate turns on 3 + DEAD_CYC edges after the release.
- R6: When any bit of oc_flag_i is high, fault_pull_o (1 = pull the shared line low) goes high 3 edges after the flag rises.
- R7: The over-temperature flag ot_flag_i drives fault_pull_o in exactly the same way as an overcurrent flag.
- R8: fault_pull_o stays high while any fault flag is high and falls 3 edges after the last one clears. The gates stay off until the shared line reads high again through the synchronizer.
- R9: The upper and lower gates of one leg are never high in the same cycle.
- R10: Phase toggling with a half-period of 500 clock cycles (100 kHz at a 100 MHz clock, default DEAD_CYC = 100) passes through with every edge reproduced and none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Per-leg switch select, 1 = upper, 0 = lower |
| leg_en_i | input | 3 | Per-leg enable, 0 = both switches off |
| en_line_i | input | 1 | Level read back from the shared active-low enable line |
| oc_flag_i | input | 3 | Overcurrent flags for the upper switches |
| ot_flag_i | input | 1 | Over-temperature flag |
| fault_pull_o | output | 1 | 1 = pull the shared enable line low |
| gate_hi_o | output | 3 | Upper gate drive per leg |
| gate_lo_o | output | 3 | Lower gate drive per leg |

## Verification
The assertions check on every cycle that no leg ever has both gates high, that a gate only turns on after a complete run of both-off cycles at least DEAD_CYC long, that a disabled leg or a low shared line leads to both-off, and that any held fault flag raises the pull-down. The bench's scenarios are what show the exact edge on which each gate changes, and the exact length of the dead time rather than only its lower bound. Only the scenarios show the full-wait restart after a leg, line or fault release, the pull-down holding across two overlapping faults, and a 100 kHz toggle running without a lost edge.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_DEAD = 2'd1,
        LEG_ON   = 2'd2
    } leg_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    function automatic gate_pair_t drive_for(leg_state_e st, logic upper);
        gate_pair_t g;
        g.hi = (st == LEG_ON) &&  upper;
        g.lo = (st == LEG_ON) && !upper;
        return g;
    endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bridge_fault.sv
module bridge_fault #(
    parameter int LEGS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEGS-1:0] oc_s,
    input  logic            ot_s,
    output logic            pull_o
);
    logic any_fault;
    assign any_fault = (|oc_s) | ot_s;

    always_ff @(posedge clk) begin
        if (rst) pull_o <= 1'b0;
        else     pull_o <= any_fault;
    end
endmodule

// File: rtl/bridge_leg.sv
module bridge_leg
    import bridge_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic phase_i,
    output logic gate_hi_o,
    output logic gate_lo_o
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
    localparam int RW = $clog2(DEAD_CYC + 2);

    leg_state_e state;
    logic       upper;
    logic [CW-1:0] cnt;
    gate_pair_t gp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LEG_OFF;
            upper <= 1'b0;
            cnt   <= '0;
        end else if (!run_i) begin
            state <= LEG_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                LEG_OFF: begin
                    state <= LEG_DEAD;
                    upper <= phase_i;
                    cnt   <= '0;
                end
                LEG_DEAD: begin
                    upper <= phase_i;
                    if (cnt == CW'(DEAD_CYC - 1)) begin
                        state <= LEG_ON;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LEG_ON: begin
                    if (phase_i != upper) begin
                        state <= LEG_DEAD;
                        upper <= phase_i;
                        cnt   <= '0;
                    end
                end
                default: state <= LEG_OFF;
            endcase
        end
    end

    assign gp        = drive_for(state, upper);
    assign gate_hi_o = gp.hi;
    assign gate_lo_o = gp.lo;

    // Run length of both-off cycles, saturating, used by the gap check.
    logic [RW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)                        off_run <= '0;
        else if (gate_hi_o || gate_lo_o) off_run <= '0;
        else if (off_run < RW'(DEAD_CYC)) off_run <= off_run + 1'b1;
    end

    p_never_both_r9: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi_o && gate_lo_o));

    p_disable_off_r2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!gate_hi_o && !gate_lo_o));

    p_dead_gap_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_hi_o) || $rose(gate_lo_o)) |-> (off_run >= RW'(DEAD_CYC)));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl #(
    parameter int LEGS     = 3,
    parameter int DEAD_CYC = 100,
    parameter int STAGES   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LEGS-1:0] phase_i,
    input  logic [LEGS-1:0] leg_en_i,
    input  logic            en_line_i,
    input  logic [LEGS-1:0] oc_flag_i,
    input  logic            ot_flag_i,
    output logic            fault_pull_o,
    output logic [LEGS-1:0] gate_hi_o,
    output logic [LEGS-1:0] gate_lo_o
);
    localparam int SW = 3 * LEGS + 2;

    logic [SW-1:0]   raw_in, syn_in;
    logic [LEGS-1:0] phase_s, leg_en_s, oc_s;
    logic            line_s, ot_s;

    assign raw_in = {ot_flag_i, oc_flag_i, en_line_i, leg_en_i, phase_i};

    bridge_sync #(.WIDTH(SW), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    assign phase_s  = syn_in[LEGS-1:0];
    assign leg_en_s = syn_in[2*LEGS-1:LEGS];
    assign line_s   = syn_in[2*LEGS];
    assign oc_s     = syn_in[3*LEGS:2*LEGS+1];
    assign ot_s     = syn_in[3*LEGS+1];

    bridge_fault #(.LEGS(LEGS)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .oc_s   (oc_s),
        .ot_s   (ot_s),
        .pull_o (fault_pull_o)
    );

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        bridge_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk       (clk),
            .rst       (rst),
            .run_i     (line_s & leg_en_s[i]),
            .phase_i   (phase_s[i]),
            .gate_hi_o (gate_hi_o[i]),
            .gate_lo_o (gate_lo_o[i])
        );
    end

    // Cycles since reset, so the input-history checks never look into reset.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    p_line_low_off_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !en_line_i && !$past(en_line_i) && !$past(en_line_i, 2))
        |=> (gate_hi_o == '0 && gate_lo_o == '0));

    p_oc_pull_r6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && |oc_flag_i && |$past(oc_flag_i) && |$past(oc_flag_i, 2)
         && $stable(oc_flag_i)) |=> fault_pull_o);

    p_ot_pull_r7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && ot_flag_i && $past(ot_flag_i) && $past(ot_flag_i, 2))
        |=> fault_pull_o);
endmodule

// File: tb/bridge_gate_ctrl_bench.sv
module bridge_gate_ctrl_bench;
    localparam int DT = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] phase = '0, leg_en = '0, oc = '0;
    logic       ot = 1'b0, ext_en = 1'b1;
    logic       pull, line;
    logic [2:0] ghi, glo;

    assign line = ext_en & ~pull;

    bridge_gate_ctrl #(.LEGS(3), .DEAD_CYC(DT), .STAGES(2)) u_bridge_gate_ctrl (
        .clk (clk), .rst (rst), .phase_i (phase), .leg_en_i (leg_en),
        .en_line_i (line), .oc_flag_i (oc), .ot_flag_i (ot),
        .fault_pull_o (pull), .gate_hi_o (ghi), .gate_lo_o (glo)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;

    typedef struct {
        int         at;
        logic [5:0] g;
        string      req;
    } ev_t;
    ev_t exp_q[$];

    // Bench model of gates: index 0..2 upper, 3..5 lower
    logic [5:0] m_g = '0;
    logic [2:0] m_en = '0, m_ph = '0;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(int at, string req);
        ev_t e;
        e.at = at; e.g = m_g; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: every change of the gate vector is compared with the queue head.
    logic [5:0] last_g = '0;
    always @(negedge clk) begin
        if (!rst && {glo, ghi} != last_g) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected gate change actual=%b expected=%b at %0d",
                         {glo, ghi}, last_g, cyc);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                if (e.g != {glo, ghi} || e.at != cyc) begin
                    n_bad++;
                    $display("FAIL %s actual=%b@%0d expected=%b@%0d",
                             e.req, {glo, ghi}, cyc, e.g, e.at);
                end
            end
            last_g = {glo, ghi};
        end
    end

    task automatic settle(int w, string req);
        repeat (w) @(negedge clk);
        check({req, " pending events"}, exp_q.size(), 0);
    endtask

    // Drive one leg and predict its gate events.
    task automatic set_leg(int i, logic en, logic ph, logic ok, int w, string req);
        int n;
        logic was_on, was_hi, go_on;
        @(negedge clk);
        n = cyc;
        leg_en[i] = en; phase[i] = ph;
        was_on = m_g[i] | m_g[i+3];
        was_hi = m_g[i];
        go_on  = en && ok;
        if (was_on && (!go_on || was_hi != ph)) begin
            m_g[i] = 1'b0; m_g[i+3] = 1'b0;
            push(n + 3, req);
        end
        if (go_on && (!was_on || was_hi != ph)) begin
            if (ph) m_g[i] = 1'b1; else m_g[i+3] = 1'b1;
            push(n + 3 + DT, req);
        end
        m_en[i] = en; m_ph[i] = ph;
        settle(w, req);
    endtask

    task automatic restore_all(int at, string req);
        for (int i = 0; i < 3; i++)
            if (m_en[i]) begin
                if (m_ph[i]) m_g[i] = 1'b1; else m_g[i+3] = 1'b1;
            end
        if (m_g != '0) push(at, req);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset gates", {glo, ghi}, 0);
        check("R6 reset pull", pull, 0);

        // R1 / R5: bring legs up from off
        set_leg(0, 1, 1, 1, DT + 10, "R1 leg0 upper");
        set_leg(1, 1, 0, 1, DT + 10, "R1 leg1 lower");
        set_leg(2, 1, 1, 1, DT + 10, "R5 leg2 start");

        // R4: switch over with dead time
        set_leg(0, 1, 0, 1, DT + 10, "R4 leg0 to lower");
        set_leg(0, 1, 1, 1, DT + 10, "R4 leg0 to upper");

        // R2: leg disable, then ignored phase changes
        set_leg(1, 0, 0, 1, 20, "R2 leg1 off");
        set_leg(1, 0, 1, 1, DT + 10, "R2 leg1 phase ignored");
        set_leg(1, 0, 0, 1, DT + 10, "R2 leg1 phase ignored");
        set_leg(1, 1, 1, 1, DT + 10, "R5 leg1 re-enable");

        // R3: shared line pulled low externally
        @(negedge clk); n = cyc; ext_en = 1'b0;
        m_g = '0; push(n + 3, "R3 line low");
        settle(DT + 10, "R3");
        check("R3 pull stays low", pull, 0);
        @(negedge clk); n = cyc; ext_en = 1'b1;
        restore_all(n + 3 + DT, "R5 line release");
        settle(DT + 10, "R5");

        // R6 / R8: overcurrent then overlapping over-temperature
        @(negedge clk); n = cyc; oc[2] = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 pull before latency", pull, 0);
        @(negedge clk);
        check("R6 pull asserted", pull, 1);
        m_g = '0; push(n + 6, "R6 gates off on fault");
        settle(40, "R6");
        @(negedge clk); ot = 1'b1;
        repeat (5) @(negedge clk); oc[2] = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 pull held by other flag", pull, 1);
        check("R8 gates still off", {glo, ghi}, 0);
        @(negedge clk); n = cyc; ot = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 pull released", pull, 0);
        restore_all(n + 6 + DT, "R8 restart after fault");
        settle(DT + 10, "R8");

        // R7: over-temperature alone
        @(negedge clk); n = cyc; ot = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 pull on over-temperature", pull, 1);
        m_g = '0; push(n + 6, "R7 gates off");
        settle(30, "R7");
        @(negedge clk); n = cyc; ot = 1'b0;
        restore_all(n + 6 + DT, "R7 restart");
        settle(DT + 10, "R7");

        // R10: 100 kHz toggle, half period 500 cycles
        for (int k = 0; k < 6; k++)
            set_leg(2, 1, k[0], 1, 499, "R10 fast toggle");

        settle(20, "end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule